// File: doc/BRIEF.md
# Peripheral Interrupt Flag and Enable Logic

This block keeps the interrupt state of a byte-wide peripheral adapter that presents sixteen byte registers to a host. Seven event sources (two timers, a shift register and four handshake lines) each raise a flag bit with a one-cycle pulse. The host clears flags by writing ones to the flag register, or as a side effect of reading certain data registers. It enables or disables sources through an enable register whose top bit of write data chooses between setting and clearing.

Reads of the flag and enable registers return a registered byte. In a flag readback, bit 7 is a summary: it is 1 when any flagged source is also enabled. The block drives one registered, active-high interrupt request. Only the shift-register source and the two timer sources can raise that request.

Top module: `ifl_irq_ctrl`

## Requirements
- R1: After synchronous reset, all flag bits and all enable bits are 0, irq is low and rdata is 0x00.
- R2: A 1 on src_set bit i sets flag bit i on the next clock edge. The bit map is CA2=0, CA1=1, SR=2, CB2=3, CB1=4, T2=5 and T1=6.
- R3: A write to the flag address (0xD) clears every flag bit whose wdata bit is 1 and leaves the others unchanged. wdata bit 7 has no effect.
- R4: A write to the enable address (0xE) with wdata bit 7 = 1 sets each enable bit whose wdata bit (6:0) is 1. Other enable bits are unchanged.
- R5: A write to the enable address with wdata bit 7 = 0 clears each enable bit whose wdata bit (6:0) is 1. Other enable bits are unchanged.
- R6: A read of the enable address returns {1, enables[6:0]}.
- R7: A read of the flag address returns flags[6:0] in bits 6:0. Bit 7 is 1 exactly when (flags AND enables) is nonzero over all seven bits.
- R8: A read of the shift data address (0xA) clears the SR, CB1 and CB2 flags.
- R9: A read of the timer-1 low count address (0x4) clears the T1 flag. A read of the timer-2 low count address (0x8) clears the T2 flag.
- R10: irq is high exactly when (flags AND enables) is nonzero in the SR, T1 or T2 bit. CA1, CA2, CB1 and CB2 never raise irq.
- R11: When a set pulse and a clear of the same flag bit (by write or by read) fall in the same cycle, the bit ends up set.
- R12: irq changes one clock after the flag or enable change that causes it.
- R13: rdata is registered and takes its new value on the clock edge that samples rd_en. Reads of any address other than the flag or enable address return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle |
| rd_en | input | 1 | Host read strobe, one cycle |
| addr | input | 4 | Register address within the 16-byte window |
| wdata | input | 8 | Write data |
| src_set | input | 7 | Per-source flag set pulses |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The bench sweeps every flag pattern against a spread of enable patterns. For each pair it checks the pin and both readbacks against values computed arithmetically. The sweep catches a design whose summary bit is limited to the three pin sources, and a design whose pin responds to a handshake flag. Directed cases target clears that are too wide: a flag write that honours bit 7, a shift-data read that misses CB1 or CB2, or a timer read that clears both timer flags. They also target an enable write that decodes bit 7 wrongly, so that a clear turns into a set. A set pulse that loses to a same-cycle clear is caught, and so is an interrupt pin that moves in the same cycle as the flag instead of one cycle later.

// File: rtl/ifl_pkg.sv
package ifl_pkg;
  localparam int unsigned SRC_N  = 7;
  localparam int unsigned DATA_W = SRC_N + 1;

  localparam int unsigned BIT_CA2 = 0;
  localparam int unsigned BIT_CA1 = 1;
  localparam int unsigned BIT_SR  = 2;
  localparam int unsigned BIT_CB2 = 3;
  localparam int unsigned BIT_CB1 = 4;
  localparam int unsigned BIT_T2  = 5;
  localparam int unsigned BIT_T1  = 6;

  typedef logic [SRC_N-1:0] src_vec_t;

  function automatic src_vec_t bit_of(input int unsigned idx);
    src_vec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  localparam src_vec_t PIN_MASK = bit_of(BIT_SR) | bit_of(BIT_T1) | bit_of(BIT_T2);
endpackage

// File: rtl/ifl_decode.sv
module ifl_decode
  import ifl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned A_FLAG  = 13,
  parameter int unsigned A_ENA   = 14,
  parameter int unsigned A_SHIFT = 10,
  parameter int unsigned A_T1LO  = 4,
  parameter int unsigned A_T2LO  = 8
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output src_vec_t          wr_clr,
  output logic              ena_wr,
  output src_vec_t          rd_clr,
  output logic              rd_flag,
  output logic              rd_ena
);
  localparam logic [ADDR_W-1:0] AF = ADDR_W'(A_FLAG);
  localparam logic [ADDR_W-1:0] AE = ADDR_W'(A_ENA);
  localparam logic [ADDR_W-1:0] AS = ADDR_W'(A_SHIFT);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(A_T1LO);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(A_T2LO);

  always_comb begin
    wr_clr  = '0;
    ena_wr  = wr_en && (addr == AE);
    rd_flag = rd_en && (addr == AF);
    rd_ena  = rd_en && (addr == AE);
    rd_clr  = '0;
    if (wr_en && (addr == AF)) wr_clr = wdata[SRC_N-1:0];
    if (rd_en) begin
      if (addr == AS) rd_clr = bit_of(BIT_SR) | bit_of(BIT_CB1) | bit_of(BIT_CB2);
      else if (addr == A1) rd_clr = bit_of(BIT_T1);
      else if (addr == A2) rd_clr = bit_of(BIT_T2);
    end
  end
endmodule

// File: rtl/ifl_flag_bank.sv
module ifl_flag_bank
  import ifl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  src_vec_t set_i,
  input  src_vec_t clr_i,
  output src_vec_t flags_o
);
  always_ff @(posedge clk) begin
    if (rst) flags_o <= '0;
    else     flags_o <= (flags_o & ~clr_i) | set_i;
  end

  // R11 / R2: a pulsed bit is set on the next edge, whatever the clear mask
  a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

  // R3: cleared bits without a same-cycle set end up 0
  a_r3_clear_bits: assert property (@(posedge clk) disable iff (rst)
    (clr_i != '0) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/ifl_enable_bank.sv
module ifl_enable_bank
  import ifl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output src_vec_t          ena_o
);
  logic     set_mode;
  src_vec_t sel;

  assign set_mode = wdata_i[DATA_W-1];
  assign sel      = wdata_i[SRC_N-1:0];

  always_ff @(posedge clk) begin
    if (rst) ena_o <= '0;
    else if (wr_i) begin
      if (set_mode) ena_o <= ena_o | sel;
      else          ena_o <= ena_o & ~sel;
    end
  end

  // R4: set mode turns selected bits on, keeps the rest
  a_r4_enable_set: assert property (@(posedge clk) disable iff (rst)
    (wr_i && set_mode) |=> (((ena_o & $past(sel)) == $past(sel)) &&
                            ((ena_o & ~$past(sel)) == ($past(ena_o) & ~$past(sel)))));

  // R5: clear mode turns selected bits off, keeps the rest
  a_r5_enable_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !set_mode) |=> (((ena_o & $past(sel)) == '0) &&
                             ((ena_o & ~$past(sel)) == ($past(ena_o) & ~$past(sel)))));
endmodule

// File: rtl/ifl_irq_out.sv
module ifl_irq_out
  import ifl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  src_vec_t flags_i,
  input  src_vec_t ena_i,
  output logic     irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(flags_i & ena_i & PIN_MASK);
  end
endmodule

// File: rtl/ifl_irq_ctrl.sv
module ifl_irq_ctrl
  import ifl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned A_FLAG  = 13,
  parameter int unsigned A_ENA   = 14,
  parameter int unsigned A_SHIFT = 10,
  parameter int unsigned A_T1LO  = 4,
  parameter int unsigned A_T2LO  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [6:0]        src_set,
  output logic [7:0]        rdata,
  output logic              irq
);
  src_vec_t wr_clr, rd_clr, flags, ena;
  logic     ena_wr, rd_flag, rd_ena;

  ifl_decode #(
    .ADDR_W(ADDR_W), .A_FLAG(A_FLAG), .A_ENA(A_ENA),
    .A_SHIFT(A_SHIFT), .A_T1LO(A_T1LO), .A_T2LO(A_T2LO)
  ) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .wr_clr(wr_clr), .ena_wr(ena_wr), .rd_clr(rd_clr),
    .rd_flag(rd_flag), .rd_ena(rd_ena)
  );

  ifl_flag_bank u_flags (
    .clk(clk), .rst(rst), .set_i(src_set),
    .clr_i(wr_clr | rd_clr), .flags_o(flags)
  );

  ifl_enable_bank u_ena (
    .clk(clk), .rst(rst), .wr_i(ena_wr), .wdata_i(wdata), .ena_o(ena)
  );

  ifl_irq_out u_irq (
    .clk(clk), .rst(rst), .flags_i(flags), .ena_i(ena), .irq_o(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      if (rd_flag)     rdata <= {|(flags & ena), flags};
      else if (rd_ena) rdata <= {1'b1, ena};
      else             rdata <= '0;
    end
  end

  // R6: enable readback always shows bit 7 high
  a_r6_enable_msb: assert property (@(posedge clk) disable iff (rst)
    rd_ena |=> rdata[7]);

  // R13: addresses owned elsewhere read back as zero
  a_r13_foreign_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_flag && !rd_ena) |=> (rdata == '0));

  // R10 / R12: a rising request needs an enabled pin source one cycle before
  a_r10_rise_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past((flags & ena & PIN_MASK) != '0));
endmodule

// File: tb/tb_ifl_irq_ctrl.sv
module tb_ifl_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] AF = 4'hD, AE = 4'hE, AS = 4'hA, A1 = 4'h4, A2 = 4'h8;
  localparam logic [6:0] PINM = 7'h64;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [6:0] src_set = '0;
  logic irq;
  int n_chk = 0, n_fail = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifl_irq_ctrl dut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .src_set(src_set), .rdata(rdata), .irq(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input logic [6:0] m);
    src_set = m;
    @(negedge clk);
    src_set = '0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 rdata", rdata, 8'h00);
    rd(AF, rv); chk("R1 flags", rv, 8'h00);
    rd(AE, rv); chk("R1 enables R6", rv, 8'h80);

    // Sweep: R2 R4 R6 R7 R10
    for (int e = 0; e < 128; e += 7) begin
      for (int f = 0; f < 128; f++) begin
        wr(AE, 8'h7F);
        wr(AE, 8'h80 | 8'(e));
        pulse(7'(f));
        idle();
        chk("R10 irq sweep", {7'd0, irq}, {7'd0, |(7'(f) & 7'(e) & PINM)});
        rd(AF, rv);
        chk("R2 R7 flag read", rv, {|(7'(f) & 7'(e)), 7'(f)});
        rd(AE, rv);
        chk("R4 R6 enable read", rv, {1'b1, 7'(e)});
        wr(AF, 8'h7F);
      end
    end

    // R3 partial clear, bit 7 ignored
    wr(AE, 8'h7F);
    pulse(7'h7F);
    wr(AF, 8'h81);
    rd(AF, rv); chk("R3 partial clear", rv, 8'h7E);
    wr(AF, 8'h80);
    rd(AF, rv); chk("R3 bit7 ignored", rv, 8'h7E);
    wr(AF, 8'h7F);

    // R5 enable clear
    wr(AE, 8'hFF);
    wr(AE, 8'h05);
    rd(AE, rv); chk("R5 enable clear", rv, 8'hFA);

    // R8 R9 read side effects, R13 foreign read zero
    wr(AE, 8'hFF);
    pulse(7'h7F);
    rd(AS, rv); chk("R13 foreign read", rv, 8'h00);
    rd(AF, rv); chk("R8 shift read clear", rv, 8'hE3);
    rd(A1, rv);
    rd(AF, rv); chk("R9 t1 read clear", rv, 8'hA3);
    rd(A2, rv);
    rd(AF, rv); chk("R9 t2 read clear", rv, 8'h83);
    idle();
    chk("R10 handshake no irq", {7'd0, irq}, 8'h00);
    wr(AF, 8'h7F);

    // R11 set beats same-cycle write clear and read clear
    wr(AE, 8'h7F);
    src_set = 7'h04; wr_en = 1'b1; addr = AF; wdata = 8'h04;
    @(negedge clk);
    src_set = '0; wr_en = 1'b0;
    rd(AF, rv); chk("R11 set over write clear", rv, 8'h04);
    src_set = 7'h10; rd_en = 1'b1; addr = AS;
    @(negedge clk);
    src_set = '0; rd_en = 1'b0;
    rd(AF, rv); chk("R11 set over read clear", rv, 8'h10);
    wr(AF, 8'h7F);

    // R12 one-cycle irq latency, set and clear
    wr(AE, 8'hC0);
    idle();
    pulse(7'h40);
    chk("R12 irq not yet", {7'd0, irq}, 8'h00);
    idle();
    chk("R12 irq raised", {7'd0, irq}, 8'h01);
    wr(AF, 8'h40);
    chk("R12 irq still high", {7'd0, irq}, 8'h01);
    idle();
    chk("R12 irq dropped", {7'd0, irq}, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule